// File: doc/BRIEF.md
# Column-Wise Survivor Decision Store

This block holds the survivor decisions of one frame for a hard-decision trellis decoder with 8 states (constraint length 4). Every trellis step produces an 8-bit decision vector, with one bit per state, from the add-compare-select stage. The block places that vector into a register that belongs to that step alone. A traceback stage then reads the whole frame as a flat bus.

The registers are not shifted. At any clock edge, at most one stage register has its write enable raised, and that is the register of the step now arriving. A register that has been filled keeps its value for the rest of the frame. This per-register write enable stands in for per-register clock gating.

A 5-bit stage index counts the symbols accepted so far. When the last stage has been filled, a one-cycle completion pulse tells the traceback stage that the frame is ready. The register that receives each write is chosen by one of two variants, set by a parameter: a binary index with a decoder, or a one-hot ring. Both variants behave the same at the ports.

Top module: `svs_survivor_bank`

## Requirements
- R1: After synchronous reset, the stage index is 0, the completion flag is 0 and every stage register reads 0.
- R2: A strobe that is accepted while the stage index is k (k < 24) stores the decision vector in stage register k+1. Stage register j occupies bits [(j-1)*8 +: 8] of the bank output, and bit s of a slice is the decision of state s. The new value is visible after that clock edge.
- R3: Each accepted strobe increments the stage index by exactly one. The index therefore equals the number of symbols accepted since the last frame start.
- R4: In any cycle, at most one stage register changes. When no strobe is accepted, no register changes, whatever value the decision input carries.
- R5: A stage register that has been written keeps its value until that same stage is written again in a later frame.
- R6: A frame-start pulse returns the stage index to 0 and leaves the stored decisions untouched. The next accepted strobe writes stage register 1.
- R7: A strobe that arrives in the same cycle as a frame-start pulse is not accepted. It writes no register and does not advance the index.
- R8: The completion flag is high for exactly one cycle. That cycle is the one right after the 24th strobe is accepted, when the index reads 24.
- R9: When the index is 24, strobes are ignored until the next frame start. The bank and the index stay the same, and the completion flag stays low.
- R10: The binary-decoder selection variant and the ring selection variant give identical port behaviour for any stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start_i | input | 1 | One-cycle pulse that opens a new frame |
| sym_valid_i | input | 1 | Decision vector strobe |
| dec_vec_i | input | 8 | Survivor decision bits, one per state |
| bank_o | output | 192 | All stage registers; stage 1 in the low byte |
| stage_idx_o | output | 5 | Symbols accepted in the current frame |
| frame_done_o | output | 1 | One-cycle pulse when the frame is full |

## Verification
The hardest case to produce from the ports is a register that gets rewritten, or written while another stage is current. Such a fault shows only if the data differs from what the register already holds. For that reason, every frame writes values that are distinct for each stage and for each frame. The stimulus also restarts a frame part way through, pulses frame start together with a strobe, and keeps strobing after the frame is full. In all of these, a stray write would overwrite a value the bench still expects to see.

// File: rtl/svs_pkg.sv
package svs_pkg;

  localparam int unsigned DEF_STATES = 8;
  localparam int unsigned DEF_STAGES = 24;

  // How the write target is picked among the stage registers.
  typedef enum logic {
    SEL_BINARY = 1'b0,
    SEL_RING   = 1'b1
  } sel_style_e;

  function automatic int unsigned idx_width(input int unsigned n_stages);
    return $clog2(n_stages + 1);
  endfunction

endpackage

// File: rtl/svs_frame_seq.sv
module svs_frame_seq #(
  parameter int unsigned NSTAGES = svs_pkg::DEF_STAGES,
  parameter int unsigned CNTW    = svs_pkg::idx_width(NSTAGES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_start_i,
  input  logic            sym_valid_i,
  output logic            accept_o,
  output logic [CNTW-1:0] stage_idx_o,
  output logic            done_o
);

  localparam logic [CNTW-1:0] LAST_IDX = CNTW'(NSTAGES - 1);
  localparam logic [CNTW-1:0] FULL_IDX = CNTW'(NSTAGES);

  logic [CNTW-1:0] idx_q;
  logic            done_q;
  logic            full;

  assign full     = (idx_q == FULL_IDX);
  // Frame start wins over a coincident strobe; a full frame admits nothing.
  assign accept_o = sym_valid_i & ~frame_start_i & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (frame_start_i) begin
        idx_q <= '0;
      end else if (accept_o) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) done_q <= 1'b1;
      end
    end
  end

  assign stage_idx_o = idx_q;
  assign done_o      = done_q;

  // R3: one step per accepted strobe
  a_r3_index_step: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> (stage_idx_o == $past(stage_idx_o) + 1'b1));

  // R6: frame start returns the index to zero
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
    frame_start_i |=> (stage_idx_o == '0));

  // R8: completion is a single-cycle pulse seen with a full index
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r8_done_when_full: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (stage_idx_o == FULL_IDX));

  // R9: the index never runs past the frame length
  a_r9_no_overrun: assert property (@(posedge clk) disable iff (rst)
    stage_idx_o <= FULL_IDX);

endmodule

// File: rtl/svs_stage_sel.sv
module svs_stage_sel #(
  parameter int unsigned          NSTAGES   = svs_pkg::DEF_STAGES,
  parameter int unsigned          CNTW      = svs_pkg::idx_width(NSTAGES),
  parameter svs_pkg::sel_style_e  SEL_STYLE = svs_pkg::SEL_BINARY
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start_i,
  input  logic               accept_i,
  input  logic [CNTW-1:0]    stage_idx_i,
  output logic [NSTAGES-1:0] wr_en_o
);

  generate
    if (SEL_STYLE == svs_pkg::SEL_BINARY) begin : g_binary
      for (genvar k = 0; k < NSTAGES; k++) begin : g_dec
        assign wr_en_o[k] = accept_i & (stage_idx_i == CNTW'(k));
      end
    end else begin : g_ring
      logic [NSTAGES-1:0] ring_q;
      always_ff @(posedge clk) begin
        if (rst || frame_start_i) begin
          ring_q <= NSTAGES'(1);
        end else if (accept_i) begin
          ring_q <= {ring_q[NSTAGES-2:0], 1'b0};
        end
      end
      assign wr_en_o = ring_q & {NSTAGES{accept_i}};
    end
  endgenerate

  // R4: never more than one stage register enabled
  a_r4_single_enable: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en_o));

  // R2: the enabled register is the one the sequencer's index names
  a_r2_target_matches_index: assert property (@(posedge clk) disable iff (rst)
    accept_i |-> (wr_en_o[stage_idx_i] && $countones(wr_en_o) == 1));

  // R7: a frame-start cycle enables nothing
  a_r7_no_write_on_start: assert property (@(posedge clk) disable iff (rst)
    frame_start_i |-> (wr_en_o == '0));

endmodule

// File: rtl/svs_stage_reg.sv
module svs_stage_reg #(
  parameter int unsigned W = svs_pkg::DEF_STATES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  // The enable models the gated clock of this single stage register.
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (en_i) q <= d_i;
  end

  assign q_o = q;

  // R5: without its enable the register holds
  a_r5_hold_unless_enabled: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(q_o));

endmodule

// File: rtl/svs_survivor_bank.sv
module svs_survivor_bank #(
  parameter int unsigned         NSTATES   = svs_pkg::DEF_STATES,
  parameter int unsigned         NSTAGES   = svs_pkg::DEF_STAGES,
  parameter svs_pkg::sel_style_e SEL_STYLE = svs_pkg::SEL_BINARY,
  localparam int unsigned        CNTW      = svs_pkg::idx_width(NSTAGES),
  localparam int unsigned        BANKW     = NSTATES * NSTAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start_i,
  input  logic               sym_valid_i,
  input  logic [NSTATES-1:0] dec_vec_i,
  output logic [BANKW-1:0]   bank_o,
  output logic [CNTW-1:0]    stage_idx_o,
  output logic               frame_done_o
);

  logic               accept;
  logic [NSTAGES-1:0] wr_en;

  svs_frame_seq #(
    .NSTAGES (NSTAGES),
    .CNTW    (CNTW)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .frame_start_i (frame_start_i),
    .sym_valid_i   (sym_valid_i),
    .accept_o      (accept),
    .stage_idx_o   (stage_idx_o),
    .done_o        (frame_done_o)
  );

  svs_stage_sel #(
    .NSTAGES   (NSTAGES),
    .CNTW      (CNTW),
    .SEL_STYLE (SEL_STYLE)
  ) u_sel (
    .clk           (clk),
    .rst           (rst),
    .frame_start_i (frame_start_i),
    .accept_i      (accept),
    .stage_idx_i   (stage_idx_o),
    .wr_en_o       (wr_en)
  );

  generate
    for (genvar k = 0; k < NSTAGES; k++) begin : g_stage
      svs_stage_reg #(
        .W (NSTATES)
      ) u_reg (
        .clk  (clk),
        .rst  (rst),
        .en_i (wr_en[k]),
        .d_i  (dec_vec_i),
        .q_o  (bank_o[k*NSTATES +: NSTATES])
      );

      // R2: an enabled stage captures the decision vector of that cycle
      a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        wr_en[k] |=> (bank_o[k*NSTATES +: NSTATES] == $past(dec_vec_i)));
    end
  endgenerate

  // R9: a full frame freezes the whole bank until restarted
  a_r9_frozen_when_full: assert property (@(posedge clk) disable iff (rst)
    (stage_idx_o == CNTW'(NSTAGES) && !frame_start_i) |=> $stable(bank_o));

endmodule

// File: tb/tb_svs_survivor_bank.sv
`timescale 1ns/1ps
module tb_svs_survivor_bank;
  import svs_pkg::*;

  localparam int NS = 8;
  localparam int NT = 24;
  localparam int CW = $clog2(NT + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, fs, vld;
  logic [NS-1:0] dv;

  logic [NS*NT-1:0] bank_b, bank_r;
  logic [CW-1:0]    idx_b, idx_r;
  logic             done_b, done_r;

  svs_survivor_bank #(.NSTATES(NS), .NSTAGES(NT), .SEL_STYLE(SEL_BINARY)) dut (
    .clk(clk), .rst(rst), .frame_start_i(fs), .sym_valid_i(vld), .dec_vec_i(dv),
    .bank_o(bank_b), .stage_idx_o(idx_b), .frame_done_o(done_b));

  // R10: the ring variant runs on the same stimulus and the same model
  svs_survivor_bank #(.NSTATES(NS), .NSTAGES(NT), .SEL_STYLE(SEL_RING)) dut_ring (
    .clk(clk), .rst(rst), .frame_start_i(fs), .sym_valid_i(vld), .dec_vec_i(dv),
    .bank_o(bank_r), .stage_idx_o(idx_r), .frame_done_o(done_r));

  // Behavioural reference
  logic [NS-1:0] m_mem [NT];
  int            m_cnt;
  bit            m_done;
  int            n_cmp = 0;
  int            n_bad = 0;
  string         tag = "R1";
  bit            finished = 0;

  function automatic logic [NS*NT-1:0] exp_bank();
    logic [NS*NT-1:0] v;
    for (int k = 0; k < NT; k++) v[k*NS +: NS] = m_mem[k];
    return v;
  endfunction

  function automatic logic [NS-1:0] pat(int frame, int k);
    return NS'(frame * 53 + k * 29 + 8'h3C);
  endfunction

  task automatic cmp(string who, logic [NS*NT-1:0] b, logic [CW-1:0] i, logic d);
    n_cmp++;
    if (b !== exp_bank()) begin
      n_bad++;
      $display("FAIL %s %s bank (R2/R4/R5) act=%h exp=%h", tag, who, b, exp_bank());
    end
    n_cmp++;
    if (i !== CW'(m_cnt)) begin
      n_bad++;
      $display("FAIL %s %s stage index (R3) act=%0d exp=%0d", tag, who, i, m_cnt);
    end
    n_cmp++;
    if (d !== m_done) begin
      n_bad++;
      $display("FAIL %s %s done flag (R8) act=%0b exp=%0b", tag, who, d, m_done);
    end
  endtask

  // Called at a negative edge: drive, let the edge pass, update model, compare.
  task automatic step(bit f, bit v, logic [NS-1:0] d);
    fs = f; vld = v; dv = d;
    @(posedge clk);
    m_done = 0;
    if (f) m_cnt = 0;
    else if (v && m_cnt < NT) begin
      m_mem[m_cnt] = d;
      m_cnt++;
      if (m_cnt == NT) m_done = 1;
    end
    @(negedge clk);
    cmp("binary", bank_b, idx_b, done_b);
    cmp("ring",   bank_r, idx_r, done_r);
  endtask

  task automatic fill(int frame, int from, int upto, bit gaps);
    for (int k = from; k < upto; k++) begin
      if (gaps) begin
        while ($urandom % 3 == 0) step(0, 0, NS'($urandom));
      end
      step(0, 1, pat(frame, k));
    end
  endtask

  initial begin
    #500_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; fs = 0; vld = 0; dv = '0;
    for (int k = 0; k < NT; k++) m_mem[k] = '0;
    m_cnt = 0; m_done = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    tag = "R1";
    cmp("binary", bank_b, idx_b, done_b);
    cmp("ring",   bank_r, idx_r, done_r);

    // R2 R3 R5 R8: a full frame back to back
    tag = "R2";
    fill(1, 0, NT, 0);
    tag = "R8";
    step(0, 0, 8'hFF);

    // R9: strobes after a full frame are ignored
    tag = "R9";
    for (int k = 0; k < 6; k++) step(0, 1, NS'($urandom));

    // R6: restart keeps old data, first write goes to stage 1
    tag = "R6";
    step(1, 0, 8'h00);
    step(0, 0, 8'h5A);
    fill(2, 0, 5, 1);

    // R7: frame start together with a strobe, mid frame
    tag = "R7";
    step(1, 1, 8'hEE);
    fill(3, 0, 10, 1);
    step(1, 1, 8'h11);

    // R4: idle cycles with a changing decision input
    tag = "R4";
    for (int k = 0; k < 8; k++) step(0, 0, NS'($urandom));

    // R5: a full gapped frame, then a second with strobes after the end
    tag = "R5";
    fill(4, 0, NT, 1);
    step(0, 1, 8'hC3);
    tag = "R10";
    step(1, 0, 8'h00);
    fill(5, 0, NT, 1);
    for (int k = 0; k < 4; k++) step(0, $urandom % 2, NS'($urandom));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule